// File: doc/BRIEF.md
# Byte-Step I2C Bus Master

This block is a single-master I2C controller that advances the bus one byte-level event at a time. Software, or a small sequencer, writes a control byte to launch one step: a start, a stop, or one byte moved in either direction. When the step ends, the engine raises an event flag and shows a 5-bit outcome code in bits 7:3 of its status byte. It then freezes the bus with SCL pulled low until the flag is cleared. Writing a one to the flag bit both clears it and launches the next step, as the control bits in that same write select.

The engine drives both lines as open-drain pull-downs. It has an 8-bit data byte, and a bit-rate byte plus a 2-bit prescaler that together set the SCL period. The first byte sent after a start is the address, and its bit 0 selects the direction. During receive, an acknowledge-enable bit decides whether each byte is answered with ACK or NACK. If the engine releases SDA during an address or data bit and then reads it low, it has lost arbitration. It then lets go of both lines.

Top module: `i2c_step_master`

## Requirements
- R1: After reset, the control byte reads 0x00, the status byte reads 0xF8, the event flag is low and neither line is pulled low.
- R2: Register addresses are 0 control, 1 status, 2 data, 3 bit rate. Control bits: 7 event flag (a write of 1 clears it and launches), 6 ack enable, 5 start, 4 stop, 2 enable. Status bits: 7:3 code, 2 zero, 1:0 prescaler (read/write).
- R3: A start on a free bus ends with code 0x08, and a start while the engine owns the bus ends with 0x10. The start bit clears itself when the start completes.
- R4: Bit 0 of the first byte after a start selects the direction (1 = read). A write address ends with 0x18 on ACK and 0x20 on NACK, and a read address ends with 0x40 or 0x48. A data byte sent ends with 0x28 on ACK and 0x30 on NACK. Bytes go out MSB first.
- R5: Each received byte is placed in the data register. It is answered with ACK and code 0x50 when ack enable is 1, and with NACK and code 0x58 when ack enable is 0.
- R6: While the event flag is high (except after arbitration loss), SCL stays pulled low for any length of time. A control write with bit 7 at 0 changes nothing on the bus.
- R7: The status code is 0x1F (byte 0xF8 with prescaler 0) exactly when the event flag is low, including while a step is in progress.
- R8: A stop request places a stop condition, releases both lines and clears the stop and start bits, and it does not raise the event flag. Stop takes priority over start in the same write.
- R9: During a byte, one SCL period is 16 + 2·rate·4^prescaler clock cycles, with equal low and high halves.
- R10: If SDA reads low at the end of a bit the engine sends as 1, both lines are released, the flag rises with code 0x38 and the bus counts as free. A following launch with neither start nor stop does nothing.
- R11: With enable at 0, launches are ignored and both lines stay released.
- R12: During a byte or acknowledge bit, SDA changes only while SCL is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at reg_addr |
| irq_o | output | 1 | Event flag |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
A behavioural slave at address 0x2A acknowledges writes and returns 0xB4, then 0xC5, on reads. It refuses the data byte 0xEE, so the bench can reach every code. A wrong repeated-start decision would show 0x08 where 0x10 is due. A swapped ack-enable sense would return the wrong ACK on a read byte, and the slave would then keep driving the next byte. The SCL period is measured at two prescaler settings, where a wrong shift would give an off-by-4^n period. Other cases covered are arbitration loss with a rival pulling SDA, an ignored launch while disabled or after loss, and a control write without the flag bit, where an engine that resumes would let SCL go.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_STOP,
        S_BIT,
        S_ACK
    } eng_state_e;

    typedef logic [4:0] code_t;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;

    localparam code_t C_START   = 5'h01;
    localparam code_t C_RSTART  = 5'h02;
    localparam code_t C_AW_ACK  = 5'h03;
    localparam code_t C_AW_NAK  = 5'h04;
    localparam code_t C_DT_ACK  = 5'h05;
    localparam code_t C_DT_NAK  = 5'h06;
    localparam code_t C_ARB     = 5'h07;
    localparam code_t C_AR_ACK  = 5'h08;
    localparam code_t C_AR_NAK  = 5'h09;
    localparam code_t C_RX_ACK  = 5'h0A;
    localparam code_t C_RX_NAK  = 5'h0B;
    localparam code_t C_NONE    = 5'h1F;

    localparam int CB_FLAG  = 7;
    localparam int CB_ACKEN = 6;
    localparam int CB_STA   = 5;
    localparam int CB_STO   = 4;
    localparam int CB_EN    = 2;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;
    localparam logic [1:0] RA_RATE = 2'd3;

    function automatic int unsigned half_cycles(int unsigned rate, int unsigned scale);
        return 32'd8 + (rate << (2 * scale));
    endfunction

endpackage

// File: rtl/i2cb_halfper.sv
module i2cb_halfper #(
    parameter int BRW  = 8,
    parameter int CNTW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           restart,
    input  logic [BRW-1:0] rate,
    input  logic [1:0]     scale,
    output logic           tick
);
    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] reload;

    always_comb reload = CNTW'(i2cb_pkg::half_cycles(32'(rate), 32'(scale)) - 32'd1);

    assign tick = (cnt == '0) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= reload;
        else if (cnt == '0)
            cnt <= reload;
        else
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/i2cb_shift.sv
module i2cb_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q,
    output logic         last
);
    localparam int CW = $clog2(W + 1);
    logic [CW-1:0] cnt;

    assign last = (cnt == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            cnt <= '0;
        end else if (load) begin
            q   <= load_val;
            cnt <= '0;
        end else if (shift) begin
            q   <= {q[W-2:0], sin};
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
    import i2cb_pkg::*;
#(
    parameter int DW   = 8,
    parameter int BRW  = 8,
    parameter int CNTW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_o,
    output logic          scl_oe_o,
    output logic          sda_oe_o,
    input  logic          sda_i
);
    eng_state_e     state;
    logic [1:0]     ph;
    logic           hi;
    logic           ctl_en, ctl_ea, ctl_sta, ctl_sto;
    logic           flag;
    code_t          code;
    logic [1:0]     presc;
    logic [BRW-1:0] rate_q;
    logic [DW-1:0]  data_q;
    logic           owned, rx_mode, addr_phase;
    logic           scl_hold, sda_hold;
    line_drive_t    drv;

    logic           tick, sh_last;
    logic [DW-1:0]  sh_q;

    wire wr_ctrl   = reg_we && (reg_addr == RA_CTRL);
    wire busy      = (state != S_IDLE);
    wire launch    = wr_ctrl && reg_wdata[CB_FLAG] && reg_wdata[CB_EN] && !busy;
    wire go_byte   = launch && !reg_wdata[CB_STO] && !reg_wdata[CB_STA] && owned;
    wire bit_end   = (state == S_BIT) && hi && tick && ctl_en;
    wire lost_now  = bit_end && !rx_mode && sh_q[DW-1] && !sda_i;
    wire bus_ack   = !sda_i;

    i2cb_halfper #(.BRW(BRW), .CNTW(CNTW)) i_div (
        .clk(clk), .rst(rst), .restart(launch),
        .rate(rate_q), .scale(presc), .tick(tick)
    );

    i2cb_shift #(.W(DW)) i_shift (
        .clk(clk), .rst(rst),
        .load(go_byte), .load_val(rx_mode ? '0 : data_q),
        .shift(bit_end && !lost_now), .sin(sda_i),
        .q(sh_q), .last(sh_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;   ph <= '0;        hi <= 1'b0;
            ctl_en <= 1'b0;    ctl_ea <= 1'b0;  ctl_sta <= 1'b0; ctl_sto <= 1'b0;
            flag <= 1'b0;      code <= C_NONE;  presc <= '0;
            rate_q <= '0;      data_q <= '0;
            owned <= 1'b0;     rx_mode <= 1'b0; addr_phase <= 1'b0;
            scl_hold <= 1'b0;  sda_hold <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctl_ea  <= reg_wdata[CB_ACKEN];
                ctl_sta <= reg_wdata[CB_STA];
                ctl_sto <= reg_wdata[CB_STO];
                ctl_en  <= reg_wdata[CB_EN];
                if (reg_wdata[CB_FLAG]) begin
                    flag <= 1'b0;
                    code <= C_NONE;
                end
            end
            if (reg_we && reg_addr == RA_STAT) presc  <= reg_wdata[1:0];
            if (reg_we && reg_addr == RA_DATA) data_q <= reg_wdata;
            if (reg_we && reg_addr == RA_RATE) rate_q <= BRW'(reg_wdata);

            if (!ctl_en) begin
                state <= S_IDLE; owned <= 1'b0; scl_hold <= 1'b0; sda_hold <= 1'b0;
            end else if (busy && tick) begin
                case (state)
                    S_START: begin
                        if (ph == 2'd3) begin
                            state <= S_IDLE;  flag <= 1'b1;
                            code <= owned ? C_RSTART : C_START;
                            owned <= 1'b1;    addr_phase <= 1'b1; rx_mode <= 1'b0;
                            scl_hold <= 1'b1; sda_hold <= 1'b1;   ctl_sta <= 1'b0;
                        end else ph <= ph + 1'b1;
                    end
                    S_STOP: begin
                        if (ph == 2'd2) begin
                            state <= S_IDLE;  owned <= 1'b0;
                            scl_hold <= 1'b0; sda_hold <= 1'b0;
                            ctl_sto <= 1'b0;  ctl_sta <= 1'b0;
                        end else ph <= ph + 1'b1;
                    end
                    S_BIT: begin
                        if (!hi) hi <= 1'b1;
                        else if (lost_now) begin
                            state <= S_IDLE;  flag <= 1'b1; code <= C_ARB;
                            owned <= 1'b0;    scl_hold <= 1'b0; sda_hold <= 1'b0;
                        end else begin
                            hi <= 1'b0;
                            if (sh_last) state <= S_ACK;
                        end
                    end
                    S_ACK: begin
                        if (!hi) hi <= 1'b1;
                        else begin
                            state <= S_IDLE;  flag <= 1'b1;
                            scl_hold <= 1'b1; sda_hold <= 1'b0;
                            if (rx_mode) begin
                                data_q <= sh_q;
                                code   <= ctl_ea ? C_RX_ACK : C_RX_NAK;
                            end else if (addr_phase) begin
                                addr_phase <= 1'b0;
                                if (data_q[0]) begin
                                    rx_mode <= 1'b1;
                                    code    <= bus_ack ? C_AR_ACK : C_AR_NAK;
                                end else
                                    code    <= bus_ack ? C_AW_ACK : C_AW_NAK;
                            end else
                                code <= bus_ack ? C_DT_ACK : C_DT_NAK;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end

            if (launch) begin
                ph <= '0;
                hi <= 1'b0;
                if (reg_wdata[CB_STO])      state <= S_STOP;
                else if (reg_wdata[CB_STA]) state <= S_START;
                else if (owned)             state <= S_BIT;
            end
        end
    end

    always_comb begin
        drv.scl_low = scl_hold;
        drv.sda_low = sda_hold;
        case (state)
            S_START: begin
                drv.scl_low = (ph == 2'd0) || (ph == 2'd3);
                drv.sda_low = (ph >= 2'd2);
            end
            S_STOP: begin
                drv.scl_low = (ph == 2'd0);
                drv.sda_low = (ph != 2'd2);
            end
            S_BIT: begin
                drv.scl_low = !hi;
                drv.sda_low = !rx_mode && !sh_q[DW-1];
            end
            S_ACK: begin
                drv.scl_low = !hi;
                drv.sda_low = rx_mode && ctl_ea;
            end
            default: ;
        endcase
    end

    assign scl_oe_o = drv.scl_low;
    assign sda_oe_o = drv.sda_low;
    assign irq_o    = flag;

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = DW'({flag, ctl_ea, ctl_sta, ctl_sto, 1'b0, ctl_en, 2'b00});
            RA_STAT: reg_rdata = DW'({code, 1'b0, presc});
            RA_DATA: reg_rdata = data_q;
            default: reg_rdata = DW'(rate_q);
        endcase
    end

    // R7: the code shows "no state" exactly when the flag is low
    p_flag_code_r7: assert property (@(posedge clk) disable iff (rst)
        flag != (code == C_NONE));

    // R6: a pending event keeps SCL low
    p_hold_scl_r6: assert property (@(posedge clk) disable iff (rst)
        (flag && $past(flag) && code != C_ARB && ctl_en && $past(ctl_en)) |-> scl_oe_o);

    // R8: finishing a stop frees the bus without an event
    p_stop_done_r8: assert property (@(posedge clk) disable iff (rst)
        (state == S_STOP && ph == 2'd2 && tick && ctl_en && !reg_we)
        |=> (!scl_oe_o && !sda_oe_o && !ctl_sto && !flag));

    // R11: disabled engine leaves both lines alone
    p_disabled_r11: assert property (@(posedge clk) disable iff (rst)
        (!ctl_en && $past(!ctl_en)) |-> (!scl_oe_o && !sda_oe_o));

    // R12: no SDA edge while SCL is released inside a byte
    p_sda_stable_r12: assert property (@(posedge clk) disable iff (rst)
        ((state == S_BIT || state == S_ACK) && ($past(state) == S_BIT || $past(state) == S_ACK)
         && !scl_oe_o && $past(!scl_oe_o)) |-> $stable(sda_oe_o));
endmodule

// File: tb/test_i2c_step_master.sv
module test_i2c_step_master;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_o, scl_oe, sda_oe;
    logic       rival = 1'b0;
    logic       s_drv = 1'b0;
    wire        scl_w = ~scl_oe;
    wire        sda_w = ~(sda_oe | s_drv | rival);

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    i2c_step_master i_i2c_step_master (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_w)
    );

    // ---------------- slave model at address 0x2A ----------------
    logic [7:0] s_sh = 8'h00, s_tx = 8'h00, s_last = 8'h00;
    logic [3:0] s_cnt = 4'd0;
    logic s_act = 1'b0, s_addr = 1'b0, s_rd = 1'b0, s_match = 1'b0, s_mack = 1'b0;
    int   s_wcnt = 0;

    always @(negedge sda_w) if (scl_w === 1'b1) begin
        s_act = 1'b1; s_addr = 1'b1; s_cnt = 4'd0; s_drv = 1'b0;
    end
    always @(posedge sda_w) if (scl_w === 1'b1) begin
        s_act = 1'b0; s_drv = 1'b0;
    end
    always @(posedge scl_w) if (s_act) begin
        if (s_cnt < 4'd8) s_sh = {s_sh[6:0], sda_w};
        else              s_mack = sda_w;
        s_cnt = s_cnt + 4'd1;
    end
    always @(negedge scl_w) if (s_act) begin
        if (s_cnt == 4'd8) begin
            if (s_addr) begin
                s_match = (s_sh[7:1] == 7'h2A); s_rd = s_sh[0]; s_drv = s_match;
            end else if (!s_rd) begin
                s_last = s_sh; s_wcnt++; s_drv = (s_sh != 8'hEE);
            end else s_drv = 1'b0;
        end else if (s_cnt == 4'd9) begin
            s_cnt = 4'd0;
            if (s_addr) begin
                s_addr = 1'b0;
                if (!s_match) begin s_act = 1'b0; s_drv = 1'b0; end
                else if (s_rd) begin s_tx = 8'hB4; s_drv = !s_tx[7]; end
                else s_drv = 1'b0;
            end else if (s_rd && !s_mack) begin
                s_tx = s_tx + 8'h11; s_drv = !s_tx[7];
            end else s_drv = 1'b0;
        end else if (s_rd && !s_addr) s_drv = !s_tx[3'(7 - s_cnt)];
        else s_drv = 1'b0;
    end

    // SDA edges while SCL released (R12 monitor)
    int  hi_edges = 0;
    logic p_scl = 1'b0, p_sda = 1'b0;
    always @(negedge clk) begin
        if (!rst && !scl_oe && !p_scl && (sda_oe != p_sda)) hi_edges++;
        p_scl = scl_oe; p_sda = sda_oe;
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_evt(input bit for_stop, output bit ok);
        logic [7:0] c;
        int n = 0;
        ok = 1'b0;
        while (!ok && n < 5000) begin
            @(negedge clk); rd(2'd0, c);
            ok = for_stop ? (c[4] == 1'b0) : irq_o;
            n++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [2:0] OP_STA = 3'd0, OP_TX = 3'd1, OP_RXA = 3'd2, OP_RXN = 3'd3, OP_STO = 3'd4;

    task automatic do_op(input logic [2:0] op, input logic [7:0] wd);
        case (op)
            OP_STA: wr(2'd0, 8'hA4);
            OP_TX:  begin wr(2'd2, wd); wr(2'd0, 8'h84); end
            OP_RXA: wr(2'd0, 8'hC4);
            OP_RXN: wr(2'd0, 8'h84);
            default: wr(2'd0, 8'h94);
        endcase
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            OP_STA:         return "R3 start";
            OP_TX:          return "R4 transmit";
            OP_RXA, OP_RXN: return "R5 receive";
            default:        return "R8 stop";
        endcase
    endfunction

    task automatic measure(input int exp_period);
        int t = 0, t1 = -1, per = -1;
        logic prev = 1'b1;
        bit ok;
        logic [7:0] c;
        hi_edges = 0;
        wr(2'd2, 8'h54); wr(2'd0, 8'h84);
        while (per < 0 && t < 3000) begin
            @(negedge clk); t++;
            if (scl_oe && !prev) begin
                if (t1 < 0) t1 = t; else per = t - t1;
            end
            prev = scl_oe;
        end
        check("R9 scl period", per, exp_period);
        wait_evt(1'b0, ok);
        rd(2'd1, c);
        check("R4 address write ack", {c[7:3], 3'b0}, 8'h18);
        check("R12 no sda edge with scl high", hi_edges, 0);
    endtask

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] wd;
        logic [7:0] st;
        logic [7:0] rd;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        {OP_STA, 8'h00, 8'h08, 8'h00},
        {OP_TX,  8'h54, 8'h18, 8'h00},
        {OP_TX,  8'h3C, 8'h28, 8'h00},
        {OP_TX,  8'h99, 8'h28, 8'h00},
        {OP_STA, 8'h00, 8'h10, 8'h00},
        {OP_TX,  8'h55, 8'h40, 8'h00},
        {OP_RXA, 8'h00, 8'h50, 8'hB4},
        {OP_RXN, 8'h00, 8'h58, 8'hC5},
        {OP_STO, 8'h00, 8'hF8, 8'h00},
        {OP_STA, 8'h00, 8'h08, 8'h00},
        {OP_TX,  8'h20, 8'h20, 8'h00},
        {OP_STA, 8'h00, 8'h10, 8'h00},
        {OP_TX,  8'h21, 8'h48, 8'h00},
        {OP_STO, 8'h00, 8'hF8, 8'h00},
        {OP_STA, 8'h00, 8'h08, 8'h00},
        {OP_TX,  8'h54, 8'h18, 8'h00},
        {OP_TX,  8'hEE, 8'h30, 8'h00},
        {OP_STO, 8'h00, 8'hF8, 8'h00}
    };

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] c;
        bit ok;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, c); check("R1 ctrl reset", c, 8'h00);
        rd(2'd1, c); check("R1 status reset", c, 8'hF8);
        check("R1 flag reset", irq_o, 1'b0);
        check("R1 lines released", {scl_oe, sda_oe}, 2'b00);

        wr(2'd3, 8'd2);
        rd(2'd3, c); check("R2 rate readback", c, 8'd2);

        // R11 launch while disabled
        wr(2'd0, 8'hA0); idle(100);
        check("R11 disabled start ignored", {irq_o, scl_oe, sda_oe}, 3'b000);

        // vector table
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i].op, VEC[i].wd);
            wait_evt(VEC[i].op == OP_STO, ok);
            check({op_tag(VEC[i].op), " completes"}, ok, 1'b1);
            rd(2'd1, c);
            check({op_tag(VEC[i].op), " code"}, {c[7:3], 3'b0}, VEC[i].st);
            if (VEC[i].op == OP_RXA || VEC[i].op == OP_RXN) begin
                rd(2'd2, c); check("R5 received byte", c, VEC[i].rd);
            end
            if (VEC[i].op == OP_STO) begin
                @(negedge clk);
                check("R8 stop frees bus", {irq_o, scl_oe, sda_oe}, 3'b000);
                rd(2'd0, c); check("R8 stop and start bits cleared", c[5:4], 2'b00);
            end
            if (VEC[i].op == OP_STA) begin
                rd(2'd0, c); check("R3 start bit self-clears", c[5], 1'b0);
            end
        end
        check("R4 slave saw MSB-first bytes", s_last, 8'hEE);
        check("R4 slave byte count", s_wcnt, 3);

        // R6 freeze and R7 busy status
        do_op(OP_STA, 8'h00); wait_evt(1'b0, ok);
        wr(2'd0, 8'h04); idle(200);
        check("R6 flag held", irq_o, 1'b1);
        check("R6 scl held low", scl_oe, 1'b1);
        rd(2'd1, c); check("R6 code unchanged", c, 8'h08);
        wr(2'd0, 8'hB4);
        rd(2'd1, c); check("R7 status while busy", c, 8'hF8);
        check("R7 flag low while busy", irq_o, 1'b0);
        wait_evt(1'b1, ok);
        check("R8 stop wins over start", ok && !irq_o, 1'b1);

        // R9 timing at two settings
        do_op(OP_STA, 8'h00); wait_evt(1'b0, ok);
        measure(20);
        do_op(OP_STO, 8'h00); wait_evt(1'b1, ok);
        wr(2'd1, 8'h01); wr(2'd3, 8'h01);
        rd(2'd1, c); check("R2 prescaler readback", c[1:0], 2'b01);
        do_op(OP_STA, 8'h00); wait_evt(1'b0, ok);
        measure(24);
        do_op(OP_STO, 8'h00); wait_evt(1'b1, ok);
        wr(2'd1, 8'h00); wr(2'd3, 8'h02);

        // R10 arbitration loss
        do_op(OP_STA, 8'h00); wait_evt(1'b0, ok);
        rival = 1'b1;
        do_op(OP_TX, 8'hAA); wait_evt(1'b0, ok);
        rd(2'd1, c); check("R10 arbitration code", c, 8'h38);
        check("R10 lines released", {scl_oe, sda_oe}, 2'b00);
        rival = 1'b0;
        idle(5);
        wr(2'd0, 8'h84); idle(300);
        check("R10 byte launch after loss ignored", {irq_o, scl_oe, sda_oe}, 3'b000);
        do_op(OP_STA, 8'h00); wait_evt(1'b0, ok);
        rd(2'd1, c); check("R3 start after loss is fresh", c, 8'h08);
        do_op(OP_STO, 8'h00); wait_evt(1'b1, ok);
        check("R8 final stop", {irq_o, scl_oe, sda_oe}, 3'b000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule